// File: doc/BRIEF.md
# Clock Wake-Up Controller

This block turns the processor and bus clocks back on after a programmed sleep. Software stores one 32-bit control word. Its upper thirty bits give a wake-up count in steps of four cycles. Its two lowest bits decide whether an external pin and the GPIO interrupt line may cut the sleep short.

A single-cycle request puts the block to sleep. The block then acknowledges the request and drops its clock-enable output. A countdown runs on the always-running reference clock. The clock enable returns when the countdown expires or when an enabled event arrives, whichever comes first.

The external pin reaches the controller without synchronisation and passes through a two-stage synchroniser. The interrupt line is already synchronous. A cause output records which source ended the last sleep. It holds that value until the next sleep request.

Top module: `clk_wake_ctrl`

## Requirements
- R1: While reset is applied, and in the cycle after it is released, clk_en is 1, sleep_ack is 0, wake_cause is 0 (none) and cfg_rd_data is 0.
- R2: A write with cfg_wr_en stores the whole 32-bit word, and cfg_rd_data returns it from the next cycle. The wake count is the word with bits 1:0 cleared, bit 1 enables the pin event and bit 0 enables the interrupt event.
- R3: A sleep_req pulse while clk_en is 1 makes clk_en 0 and sleep_ack 1 from the next cycle. sleep_ack lasts exactly one cycle, and wake_cause becomes 0 in the same cycle.
- R4: With a wake count of N (N >= 4) and no event, clk_en stays 0 for exactly N cycles and then returns to 1, with wake_cause = 1 (timer).
- R5: A count field of zero is treated as a count of 4.
- R6: With bit 1 set, the external pin rising during sleep brings clk_en back to 1 three reference edges later (two synchroniser stages plus the wake edge), with wake_cause = 2 (pin).
- R7: With bit 0 set, gpio_irq high during a sleep cycle brings clk_en back to 1 at the next edge, with wake_cause = 3 (interrupt).
- R8: When an event's enable bit is 0, that event has no effect, and the sleep lasts the full count.
- R9: When several sources end the sleep at the same edge, wake_cause shows the highest priority among them: pin first, then interrupt, then timer.
- R10: A sleep_req during sleep has no effect on the sleep length. While awake, pin and interrupt activity do not drop clk_en and do not change wake_cause.
- R11: A register write during sleep does not change the length of the sleep in progress. The new count takes effect at the next sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word to store |
| cfg_rd_data | output | 32 | Stored control word |
| sleep_req | input | 1 | Single-cycle sleep request |
| wake_pin_async | input | 1 | External wake pin, not synchronised |
| gpio_irq | input | 1 | Synchronous GPIO interrupt line |
| sleep_ack | output | 1 | One-cycle acknowledge of sleep entry |
| clk_en | output | 1 | Enable for the gated processor and bus clocks |
| wake_cause | output | 2 | Source of the last wake: 0 none, 1 timer, 2 pin, 3 interrupt |

## Verification
The bench uses the default parameters: a 32-bit control word and two synchroniser stages. This keeps the pin latency at exactly three edges, so the latency can be predicted cycle by cycle.

Every count field from zero to 64 is swept, and the length of each sleep is compared with its arithmetic expected value. The pin and interrupt events are injected at each of the first five sleep cycles. Tie cases place an event exactly on the edge where the timer expires. Further cases cover disabled events, requests made during sleep and register writes made during sleep.

// File: rtl/cwk_pkg.sv
package cwk_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_TIMER = 2'd1,
        CAUSE_PIN   = 2'd2,
        CAUSE_IRQ   = 2'd3
    } wake_cause_t;

    typedef enum logic {
        ST_AWAKE  = 1'b0,
        ST_ASLEEP = 1'b1
    } pwr_state_t;

    typedef struct packed {
        logic pin_hit;
        logic irq_hit;
        logic tmr_hit;
    } wake_evt_t;

    localparam int unsigned MIN_WAKE_COUNT = 4;
    localparam int unsigned EN_BITS        = 2;

    function automatic logic any_wake(input wake_evt_t e);
        return e.pin_hit | e.irq_hit | e.tmr_hit;
    endfunction

    function automatic wake_cause_t pick_cause(input wake_evt_t e);
        if (e.pin_hit)      return CAUSE_PIN;
        else if (e.irq_hit) return CAUSE_IRQ;
        else if (e.tmr_hit) return CAUSE_TIMER;
        else                return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/cwk_ctrl_reg.sv
module cwk_ctrl_reg
    import cwk_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] load_count,
    output logic              pin_en,
    output logic              irq_en
);
    localparam logic [DATA_W-1:0] MIN_CNT = DATA_W'(MIN_WAKE_COUNT);

    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] raw_count;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= wr_data;
        end
    end

    always_comb begin
        raw_count  = {word_q[DATA_W-1:EN_BITS], {EN_BITS{1'b0}}};
        load_count = (raw_count == '0) ? MIN_CNT : raw_count;
    end

    assign rd_data = word_q;
    assign pin_en  = word_q[1];
    assign irq_en  = word_q[0];

endmodule

// File: rtl/cwk_sync.sv
module cwk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES:0] chain;

    assign chain[0] = d;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i+1] <= 1'b0;
            else     chain[i+1] <= chain[i];
        end
    end

    assign q = chain[STAGES];

endmodule

// File: rtl/cwk_countdown.sv
module cwk_countdown #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expire = run && (cnt_q == ONE);

endmodule

// File: rtl/cwk_seq.sv
module cwk_seq
    import cwk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sleep_req,
    input  wake_evt_t   evt,
    output logic        load,
    output logic        run,
    output logic        clk_en,
    output logic        sleep_ack,
    output wake_cause_t cause
);
    pwr_state_t  state_q;
    logic        ack_q;
    wake_cause_t cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_AWAKE;
            ack_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            ack_q <= 1'b0;
            unique case (state_q)
                ST_AWAKE: begin
                    if (sleep_req) begin
                        state_q <= ST_ASLEEP;
                        ack_q   <= 1'b1;
                        cause_q <= CAUSE_NONE;
                    end
                end
                ST_ASLEEP: begin
                    if (any_wake(evt)) begin
                        state_q <= ST_AWAKE;
                        cause_q <= pick_cause(evt);
                    end
                end
                default: state_q <= ST_AWAKE;
            endcase
        end
    end

    assign load      = (state_q == ST_AWAKE) && sleep_req;
    assign run       = (state_q == ST_ASLEEP);
    assign clk_en    = (state_q == ST_AWAKE);
    assign sleep_ack = ack_q;
    assign cause     = cause_q;

endmodule

// File: rtl/clk_wake_ctrl.sv
module clk_wake_ctrl
    import cwk_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [DATA_W-1:0] cfg_wr_data,
    output logic [DATA_W-1:0] cfg_rd_data,
    input  logic              sleep_req,
    input  logic              wake_pin_async,
    input  logic              gpio_irq,
    output logic              sleep_ack,
    output logic              clk_en,
    output logic [1:0]        wake_cause
);
    logic [DATA_W-1:0] load_count;
    logic              pin_en;
    logic              irq_en;
    logic              pin_sync;
    logic              tmr_load;
    logic              tmr_run;
    logic              tmr_expire;
    wake_evt_t         evt;
    wake_cause_t       cause;

    cwk_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_wr_en),
        .wr_data    (cfg_wr_data),
        .rd_data    (cfg_rd_data),
        .load_count (load_count),
        .pin_en     (pin_en),
        .irq_en     (irq_en)
    );

    cwk_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d   (wake_pin_async),
        .q   (pin_sync)
    );

    cwk_countdown #(.CNT_W(DATA_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (load_count),
        .run      (tmr_run),
        .expire   (tmr_expire)
    );

    always_comb begin
        evt.pin_hit = pin_en & pin_sync;
        evt.irq_hit = irq_en & gpio_irq;
        evt.tmr_hit = tmr_expire;
    end

    cwk_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .evt       (evt),
        .load      (tmr_load),
        .run       (tmr_run),
        .clk_en    (clk_en),
        .sleep_ack (sleep_ack),
        .cause     (cause)
    );

    assign wake_cause = cause;

endmodule

// File: rtl/cwk_checker.sv
module cwk_checker (
    input logic       clk,
    input logic       rst,
    input logic       sleep_req,
    input logic       gpio_irq,
    input logic       irq_en,
    input logic       clk_en,
    input logic       sleep_ack,
    input logic [1:0] wake_cause
);
    p_sleep_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (clk_en && sleep_req) |=> (sleep_ack && !clk_en && wake_cause == 2'd0));

    p_ack_single_r3: assert property (@(posedge clk) disable iff (rst)
        sleep_ack |=> !sleep_ack);

    p_stay_awake_r10: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !sleep_req) |=> (clk_en && $stable(wake_cause)));

    p_wake_has_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en) |-> (wake_cause != 2'd0));

    p_irq_wakes_r7: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && irq_en && gpio_irq) |=>
            (clk_en && (wake_cause == 2'd3 || wake_cause == 2'd2)));

    p_ack_means_asleep_r3: assert property (@(posedge clk) disable iff (rst)
        sleep_ack |-> !clk_en);
endmodule

bind clk_wake_ctrl cwk_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep_req  (sleep_req),
    .gpio_irq   (gpio_irq),
    .irq_en     (irq_en),
    .clk_en     (clk_en),
    .sleep_ack  (sleep_ack),
    .wake_cause (wake_cause)
);

// File: tb/clk_wake_ctrl_test.sv
`timescale 1ns/1ps
module clk_wake_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        sleep_req = 1'b0;
    logic        wake_pin_async = 1'b0;
    logic        gpio_irq = 1'b0;
    logic        sleep_ack;
    logic        clk_en;
    logic [1:0]  wake_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clk_wake_ctrl uut (
        .clk            (clk),
        .rst            (rst),
        .cfg_wr_en      (cfg_wr_en),
        .cfg_wr_data    (cfg_wr_data),
        .cfg_rd_data    (cfg_rd_data),
        .sleep_req      (sleep_req),
        .wake_pin_async (wake_pin_async),
        .gpio_irq       (gpio_irq),
        .sleep_ack      (sleep_ack),
        .clk_en         (clk_en),
        .wake_cause     (wake_cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [31:0] w);
        logic [31:0] c;
        c = w & 32'hFFFF_FFFC;
        return (c == 0) ? 4 : int'(c);
    endfunction

    task automatic write_cfg(input logic [31:0] w);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = w;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        chk("R2 readback", cfg_rd_data, w);
    endtask

    task automatic enter_sleep();
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk("R3 ack", {31'd0, sleep_ack}, 32'd1);
        chk("R3 clk_en low", {31'd0, clk_en}, 32'd0);
        chk("R3 cause cleared", {30'd0, wake_cause}, 32'd0);
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!clk_en && n < 10000) begin
            n++;
            @(negedge clk);
            if (n == 1) chk("R3 ack one cycle", {31'd0, sleep_ack}, 32'd0);
        end
    endtask

    task automatic settle();
        wake_pin_async = 1'b0;
        gpio_irq = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 clk_en in reset", {31'd0, clk_en}, 32'd1);
        rst = 1'b0;
        chk("R1 clk_en", {31'd0, clk_en}, 32'd1);
        chk("R1 ack", {31'd0, sleep_ack}, 32'd0);
        chk("R1 cause", {30'd0, wake_cause}, 32'd0);
        chk("R1 readback", cfg_rd_data, 32'd0);

        write_cfg(32'hFFFF_FFFF);
        write_cfg(32'hA5A5_5A5A);

        // R4 / R5 sweep over count fields 0..64, enables off
        for (int c = 0; c <= 64; c += 4) begin
            write_cfg(32'(c));
            enter_sleep();
            count_low(n);
            chk((c == 0) ? "R5 zero count length" : "R4 timer length", 32'(n), 32'(exp_len(32'(c))));
            chk("R4 timer cause", {30'd0, wake_cause}, 32'd1);
            @(negedge clk);
        end
        // low bits ignored for count (R2 / R4)
        write_cfg(32'd23 & 32'hFFFF_FFFC | 32'd0);
        enter_sleep();
        count_low(n);
        chk("R4 length 20", 32'(n), 32'd20);

        // R6 pin wake at offsets 0..4
        for (int k = 0; k < 5; k++) begin
            write_cfg(32'd200 | 32'd2);
            enter_sleep();
            repeat (k) @(negedge clk);
            wake_pin_async = 1'b1;
            n = 0;
            while (!clk_en && n < 50) begin @(negedge clk); n++; end
            chk("R6 pin latency", 32'(n), 32'd3);
            chk("R6 pin cause", {30'd0, wake_cause}, 32'd2);
            settle();
        end

        // R7 irq wake at offsets 0..4
        for (int k = 0; k < 5; k++) begin
            write_cfg(32'd200 | 32'd1);
            enter_sleep();
            repeat (k) @(negedge clk);
            gpio_irq = 1'b1;
            @(negedge clk);
            chk("R7 irq wake", {31'd0, clk_en}, 32'd1);
            chk("R7 irq cause", {30'd0, wake_cause}, 32'd3);
            settle();
        end

        // R8 disabled events
        write_cfg(32'd12);
        enter_sleep();
        wake_pin_async = 1'b1;
        gpio_irq = 1'b1;
        count_low(n);
        chk("R8 disabled length", 32'(n), 32'd12);
        chk("R8 disabled cause", {30'd0, wake_cause}, 32'd1);
        settle();
        write_cfg(32'd16 | 32'd2);
        enter_sleep();
        gpio_irq = 1'b1;
        count_low(n);
        chk("R8 irq disabled length", 32'(n), 32'd16);
        settle();

        // R9 pin and irq on same edge
        write_cfg(32'd200 | 32'd3);
        enter_sleep();
        wake_pin_async = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 still asleep", {31'd0, clk_en}, 32'd0);
        gpio_irq = 1'b1;
        @(negedge clk);
        chk("R9 pin over irq wake", {31'd0, clk_en}, 32'd1);
        chk("R9 pin over irq cause", {30'd0, wake_cause}, 32'd2);
        settle();

        // R9 irq with timer expiry
        write_cfg(32'd4 | 32'd1);
        enter_sleep();
        repeat (3) @(negedge clk);
        chk("R9 asleep cycle 4", {31'd0, clk_en}, 32'd0);
        gpio_irq = 1'b1;
        @(negedge clk);
        chk("R9 irq over timer wake", {31'd0, clk_en}, 32'd1);
        chk("R9 irq over timer cause", {30'd0, wake_cause}, 32'd3);
        settle();

        // R9 pin with timer expiry
        write_cfg(32'd4 | 32'd2);
        enter_sleep();
        @(negedge clk);
        wake_pin_async = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 asleep before tie", {31'd0, clk_en}, 32'd0);
        @(negedge clk);
        chk("R9 pin over timer wake", {31'd0, clk_en}, 32'd1);
        chk("R9 pin over timer cause", {30'd0, wake_cause}, 32'd2);
        settle();

        // R10 request during sleep
        write_cfg(32'd16);
        enter_sleep();
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk("R10 no second ack", {31'd0, sleep_ack}, 32'd0);
        count_low(n);
        chk("R10 length unchanged", 32'(n + 2), 32'd16);
        chk("R10 cause timer", {30'd0, wake_cause}, 32'd1);
        // R10 events while awake
        write_cfg(32'd16 | 32'd3);
        wake_pin_async = 1'b1;
        gpio_irq = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R10 awake stays on", {31'd0, clk_en}, 32'd1);
            chk("R10 cause held", {30'd0, wake_cause}, 32'd1);
        end
        settle();

        // R11 write during sleep
        write_cfg(32'd8);
        enter_sleep();
        write_cfg(32'd40);
        count_low(n);
        chk("R11 current sleep unchanged", 32'(n + 1), 32'd8);
        @(negedge clk);
        enter_sleep();
        count_low(n);
        chk("R11 next sleep uses new count", 32'(n), 32'd40);

        // R4 longer count
        write_cfg(32'h0000_1000);
        enter_sleep();
        count_low(n);
        chk("R4 long length", 32'(n), 32'd4096);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule